// File: doc/BRIEF.md
# Software Event Trigger Register

This block is a single 32-bit configuration register that software uses to raise one event toward a platform controller. The event can go to either of two paths. Bit 15 picks the path. When it is 1 the event goes out as a system control interrupt (SCI) message. When it is 0 the event goes out as a system management interrupt (SMI) request. Bits 15:1 are plain stored bits, and software uses them as a payload when it requests an SMI. Bit 0 is the trigger bit.

The trigger is a two-state machine with the states TRG_LOW and TRG_HIGH. The machine moves from TRG_LOW to TRG_HIGH (transition ARM) when a write that enables the low byte carries a 1 in bit 0. This is the only transition that raises an event. It moves from TRG_HIGH back to TRG_LOW (transition DISARM) when such a write carries a 0 in bit 0. All other writes leave the state where it is (transition HOLD). On ARM, a pulse one clock long appears in the cycle after the write. The pulse goes on `sci_msg` if the value of bit 15 after that write is 1, and on `smi_req` otherwise. Reads return the stored bits at all times, and bits 31:16 read as 0.

Top module: `swtrig_evt`

## Requirements
- R1: After reset, `rd_data` is 00000000h and neither `sci_msg` nor `smi_req` is high.
- R2: A write with a given byte enabled stores that byte of bits 15:1 and reads it back. Bits 31:16 always read 0, whatever was written to them.
- R3: Suppose a write enables byte 0, sets `wr_data[0]` to 1 while the stored bit 0 is 0, and leaves bit 15 at 1 after the write. Then `sci_msg` is high for exactly the one cycle after the write, and `smi_req` stays low.
- R4: Writes that take bit 0 from 1 to 1, from 1 to 0 or from 0 to 0 raise neither output.
- R5: When bit 15 is 0 after the write, a 0-to-1 write of bit 0 raises no `sci_msg`. Instead it raises `smi_req` for exactly the one cycle after the write.
- R6: Once set, bit 0 reads 1 until a write that enables byte 0 carries a 0 in bit 0. Idle cycles and writes that leave byte 0 disabled do not clear it.
- R7: When `be[0]` is 0, a write changes neither bit 0 nor bits 7:1 and raises no event. When `be[1]` is 0, bits 15:8 keep their value, and the stored bit 15 chooses the path.
- R8: A cycle with `reg_sel` or `wr_en` low changes no stored bit and raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Address decode hit for this register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| be | input | 4 | Byte enables, bit n covers data byte n |
| rd_data | output | 32 | Current register contents |
| sci_msg | output | 1 | One-cycle SCI message pulse |
| smi_req | output | 1 | One-cycle SMI request pulse |

## Verification
The trigger bit is written in all four old/new combinations. A pulse on the 0-to-1 case only shows that the edge is taken against the stored value and not against the data on the bus. That same 0-to-1 write is repeated with bit 15 set and with bit 15 clear, which separates the SCI path from the SMI path. Writes with only byte 1 enabled, only byte 0 enabled, `reg_sel` low and `wr_en` low show that the byte-lane gating and the decode qualify both storage and events. A set trigger followed by idle cycles and byte-1-only writes shows that bit 0 stays latched.

// File: rtl/swtrig_pkg.sv
package swtrig_pkg;
    typedef enum logic {
        TRG_LOW  = 1'b0,
        TRG_HIGH = 1'b1
    } trg_state_t;
endpackage

// File: rtl/swtrig_lanes.sv
module swtrig_lanes #(
    parameter int IMPL_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [IMPL_W/8-1:0]   lane_en,
    input  logic [IMPL_W-1:0]     wdata,
    output logic [IMPL_W-1:0]     store
);
    localparam int LANES = IMPL_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store[g*8 +: 8] <= '0;
            end else if (wr_stb && lane_en[g]) begin
                store[g*8 +: 8] <= wdata[g*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/swtrig_fsm.sv
module swtrig_fsm
    import swtrig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_low,
    input  logic wr_bit0,
    input  logic sel_next,
    output logic trig,
    output logic sci_msg,
    output logic smi_req
);
    trg_state_t state, state_nx;
    logic       arm;

    always_comb begin
        state_nx = state;
        arm      = 1'b0;
        unique case (state)
            TRG_LOW: begin
                if (wr_low && wr_bit0) begin
                    state_nx = TRG_HIGH;
                    arm      = 1'b1;
                end
            end
            TRG_HIGH: begin
                if (wr_low && !wr_bit0) begin
                    state_nx = TRG_LOW;
                end
            end
            default: state_nx = TRG_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRG_LOW;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_msg <= 1'b0;
            smi_req <= 1'b0;
        end else begin
            sci_msg <= arm && sel_next;
            smi_req <= arm && !sel_next;
        end
    end

    assign trig = (state == TRG_HIGH);
endmodule

// File: rtl/swtrig_evt.sv
module swtrig_evt #(
    parameter int DATA_W = 32,
    parameter int IMPL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0] rd_data,
    output logic              sci_msg,
    output logic              smi_req
);
    localparam int SEL_BIT  = IMPL_W - 1;
    localparam int SEL_LANE = SEL_BIT / 8;
    localparam int LANES    = IMPL_W / 8;

    logic              wr_stb;
    logic [IMPL_W-1:0] store;
    logic              trig;
    logic              sel_next;
    logic              unused_hi;

    assign wr_stb = reg_sel && wr_en;

    swtrig_lanes #(.IMPL_W(IMPL_W)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .lane_en (be[LANES-1:0]),
        .wdata   (wr_data[IMPL_W-1:0]),
        .store   (store)
    );

    assign sel_next = (wr_stb && be[SEL_LANE]) ? wr_data[SEL_BIT] : store[SEL_BIT];

    swtrig_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_low   (wr_stb && be[0]),
        .wr_bit0  (wr_data[0]),
        .sel_next (sel_next),
        .trig     (trig),
        .sci_msg  (sci_msg),
        .smi_req  (smi_req)
    );

    assign rd_data   = {{(DATA_W-IMPL_W){1'b0}}, store[IMPL_W-1:1], trig};
    assign unused_hi = ^{wr_data[DATA_W-1:IMPL_W], be[DATA_W/8-1:LANES], store[0]};
endmodule

// File: rtl/swtrig_evt_chk.sv
module swtrig_evt_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W/8-1:0] be,
    input logic [DATA_W-1:0] rd_data,
    input logic              sci_msg,
    input logic              smi_req
);
    // R3
    sci_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_msg |-> $past(reg_sel && wr_en && be[0] && wr_data[0] && !rd_data[0]));
    // R3
    sci_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_msg |=> !sci_msg);
    // R5
    path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sci_msg && smi_req));
    // R5
    smi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |=> !smi_req);
    // R6
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[0] && !(reg_sel && wr_en && be[0] && !wr_data[0])) |=> rd_data[0]);
    // R8
    no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && wr_en && be[0]) |=> (!sci_msg && !smi_req));
    // R8
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && wr_en) |=> $stable(rd_data));
    // R2
    always_comb begin
        upper_zero_chk: assert (rd_data[DATA_W-1:16] == '0);
    end
endmodule

bind swtrig_evt swtrig_evt_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .be      (be),
    .rd_data (rd_data),
    .sci_msg (sci_msg),
    .smi_req (smi_req)
);

// File: tb/swtrig_evt_test.sv
module swtrig_evt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  be = '0;
    logic [31:0] rd_data;
    logic        sci_msg, smi_req;
    int          errors = 0;
    int          checks = 0;

    always #5 clk = ~clk;

    swtrig_evt uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .be(be), .rd_data(rd_data),
        .sci_msg(sci_msg), .smi_req(smi_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One register access; checks pulses in the following cycle and after it.
    task automatic access(input logic sel, input logic en, input logic [31:0] d,
                          input logic [3:0] b, input logic exp_sci, input logic exp_smi,
                          input logic [31:0] exp_rd, input string tag);
        @(negedge clk);
        reg_sel = sel; wr_en = en; wr_data = d; be = b;
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b0; wr_data = '0; be = '0;
        check({tag, " sci"}, {31'd0, sci_msg}, {31'd0, exp_sci});
        check({tag, " smi"}, {31'd0, smi_req}, {31'd0, exp_smi});
        check({tag, " rd"}, rd_data, exp_rd);
        @(negedge clk);
        check({tag, " pulse end"}, {30'd0, sci_msg, smi_req}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 rd", rd_data, 32'h0);
        check("R1 pulses", {30'd0, sci_msg, smi_req}, 32'd0);
    endtask

    task automatic t_select;
        access(1, 1, 32'h0000_8000, 4'h3, 0, 0, 32'h0000_8000, "R2 select");
        access(1, 1, 32'hABCD_80FE, 4'hF, 0, 0, 32'h0000_80FE, "R2 upper zero");
        access(1, 1, 32'h0000_8000, 4'h1, 0, 0, 32'h0000_8000, "R2 low lane");
    endtask

    task automatic t_sci_edges;
        access(1, 1, 32'h0000_8001, 4'h3, 1, 0, 32'h0000_8001, "R3 rise");
        access(1, 1, 32'h0000_8001, 4'h3, 0, 0, 32'h0000_8001, "R4 one-one");
        access(1, 1, 32'h0000_8000, 4'h3, 0, 0, 32'h0000_8000, "R4 one-zero");
        access(1, 1, 32'h0000_8000, 4'h3, 0, 0, 32'h0000_8000, "R4 zero-zero");
    endtask

    task automatic t_latch;
        access(1, 1, 32'h0000_8001, 4'h1, 1, 0, 32'h0000_8001, "R6 set");
        repeat (5) @(negedge clk);
        check("R6 idle hold", rd_data, 32'h0000_8001);
        access(1, 1, 32'h0000_0000, 4'h2, 0, 0, 32'h0000_0001, "R6 R7 byte1 only");
        access(1, 1, 32'h0000_0000, 4'h1, 0, 0, 32'h0000_0000, "R6 clear");
    endtask

    task automatic t_smi;
        access(1, 1, 32'h0000_0005, 4'h3, 0, 1, 32'h0000_0005, "R5 smi rise");
        access(1, 1, 32'h0000_0005, 4'h3, 0, 0, 32'h0000_0005, "R5 smi hold");
        access(1, 1, 32'h0000_0000, 4'h3, 0, 0, 32'h0000_0000, "R5 smi clear");
    endtask

    task automatic t_lanes;
        access(1, 1, 32'h0000_8001, 4'h2, 0, 0, 32'h0000_8000, "R7 no be0");
        access(1, 1, 32'h0000_0001, 4'h1, 1, 0, 32'h0000_8001, "R7 stored select");
        access(1, 1, 32'h0000_0000, 4'hC, 0, 0, 32'h0000_8001, "R7 upper lanes");
    endtask

    task automatic t_decode;
        access(0, 1, 32'h0000_0000, 4'hF, 0, 0, 32'h0000_8001, "R8 no reg_sel");
        access(1, 0, 32'h0000_0000, 4'hF, 0, 0, 32'h0000_8001, "R8 no wr_en");
        access(1, 1, 32'h0000_8000, 4'h3, 0, 0, 32'h0000_8000, "R8 clear");
        access(0, 1, 32'h0000_8001, 4'hF, 0, 0, 32'h0000_8000, "R8 no reg_sel rise");
        access(1, 0, 32'h0000_8001, 4'hF, 0, 0, 32'h0000_8000, "R8 no wr_en rise");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_select;
        t_sci_edges;
        t_latch;
        t_smi;
        t_lanes;
        t_decode;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule